// File: doc/BRIEF.md
# Shared-Timebase Three-Channel PWM

This block produces three pulse-width modulated outputs from one common timebase. A single prescaled timer and one 8-bit period register set the frequency for every channel. Each channel keeps its own 10-bit duty value and its own mode field, so all three outputs share one frequency while their duty cycles differ. The typical load is a set of motor drivers that must run together at one switching frequency, each at its own speed.

Software programs the block through a single-cycle write port with an 8-bit data bus. The timebase is a 10-bit extended count. Its upper 8 bits are compared against the period register, and its lower 2 bits act as a sub-step fraction. A configuration input steers the output of one chosen channel, channel 1 by default, to an alternate pin.

Top module: `pwm_shared_timebase`

## Requirements
- R1: While reset is asserted and right after it, every channel pin and the alternate pin are low. After reset the period register is 255, the timer is stopped and every channel control is zero.
- R2: Write address map:
  - address 0 is the period (PR);
  - address 1 is timer control, with bit 2 the run bit and bits 1:0 the prescale;
  - address 2 clears the timebase on any write;
  - address 4+2c is the duty high byte of channel c;
  - address 5+2c is the control of channel c.
- R2 (continued): One PWM period lasts 4*(PR+1) prescaled ticks. The period is the same for every channel.
- R3: The 10-bit duty of a channel is {high byte, control bits 5:4}. The output is high from the start of a period until the extended count reaches the duty, so it is high for duty ticks.
- R4: A channel drives its pin only while control bits 3:0 equal 4'b1100. Any other value, including a control of zero, holds the pin low, and a mode write takes effect at once.
- R5: The prescale field divides the clock: 00 by 1, 01 by 4, and 10 or 11 by 16.
- R6: While the run bit is 0, every output is low and the timebase holds its value. Setting the bit again resumes counting from the held value.
- R7: A write to the clear address zeroes the timebase count and the prescaler, so a new period begins.
- R8: A duty of 0 keeps a pin low for the whole period. A duty of at least 4*(PR+1) keeps it high for the whole period.
- R9: Duty writes made while the timer runs take effect only at the start of the next period. While the timer is stopped they take effect at once.
- R10: When altSel is 1, the output of channel ALT_CH appears on altPin and its own pin is held low. When altSel is 0, altPin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 8 | Register write data |
| altSel | input | 1 | Steers channel ALT_CH to altPin |
| pwmPin | output | NUM_CH | One PWM pin per channel |
| altPin | output | 1 | Alternate pin for channel ALT_CH |

## Verification
The bench builds the block with its defaults: three channels, with channel 1 as the steerable one. With these values, each channel's own address pair, the steering path and cross-channel independence are all checked at once.

The full 8-bit period range is covered, from a 4-tick period at PR=0 to 1024 ticks at PR=255. All three prescale settings are used, so high-time counts of up to 1024 cycles in a single window test the 10-bit duty split end to end. Period windows are kept short so that mid-period duty updates, pausing the timer and clearing the count can be checked one cycle at a time.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DUTY_W  = 10;
  localparam int HI_W    = 8;
  localparam int FRAC_W  = DUTY_W - HI_W;
  localparam int ADDR_W  = 4;
  localparam int PRESC_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_TCTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 4'd2;
  localparam int                ADDR_CH_BASE = 4;

  localparam logic [3:0] MODE_PWM = 4'b1100;

  // strobes from timebase control to the channel datapath
  typedef struct packed {
    logic run;    // timer enabled
    logic tick;   // prescaled step this cycle
    logic wrap;   // period ends on this step
    logic clear;  // software clear of the count
  } strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [HI_W-1:0]   wrData,
  output strobe_t           strb,
  output logic [DUTY_W-1:0] extCount
);
  logic [HI_W-1:0]    periodReg;
  logic [1:0]         psSel;
  logic               timerOn;
  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescLim;
  logic               clearHit;
  logic               tick;
  logic               wrap;

  always_comb begin
    case (psSel)
      2'b00:   prescLim = PRESC_W'(0);
      2'b01:   prescLim = PRESC_W'(3);
      default: prescLim = PRESC_W'(15);
    endcase
  end

  assign clearHit = wrEn && (wrAddr == ADDR_CLEAR);
  assign tick     = timerOn && (prescCnt >= prescLim);
  // last step of the period, or counter overflow after a period shrink
  assign wrap     = tick && ((extCount == {periodReg, {FRAC_W{1'b1}}}) || (&extCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '1;
      psSel     <= 2'b00;
      timerOn   <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_PERIOD) periodReg <= wrData;
      if (wrAddr == ADDR_TCTRL) begin
        timerOn <= wrData[2];
        psSel   <= wrData[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
      extCount <= '0;
    end else if (clearHit) begin
      prescCnt <= '0;
      extCount <= '0;
    end else if (timerOn) begin
      prescCnt <= tick ? '0 : prescCnt + 1'b1;
      if (tick) extCount <= wrap ? '0 : extCount + 1'b1;
    end
  end

  assign strb.run   = timerOn;
  assign strb.tick  = tick;
  assign strb.wrap  = wrap;
  assign strb.clear = clearHit;
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [HI_W-1:0]   wrData,
  input  strobe_t           strb,
  input  logic [DUTY_W-1:0] extCount,
  output logic [NUM_CH-1:0] chOut
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(ADDR_CH_BASE + 2*c);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(ADDR_CH_BASE + 2*c + 1);

    logic [HI_W-1:0]   dutyHi;
    logic [5:0]        ctlReg;
    logic [DUTY_W-1:0] bufDuty;
    logic [DUTY_W-1:0] activeDuty;

    assign bufDuty = {dutyHi, ctlReg[5:4]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dutyHi <= '0;
        ctlReg <= '0;
      end else if (wrEn) begin
        if (wrAddr == HI_A)  dutyHi <= wrData;
        if (wrAddr == CTL_A) ctlReg <= wrData[5:0];
      end
    end

    // shadow copy: follows the buffer while stopped, loads at period start
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      activeDuty <= '0;
      else if (!strb.run || strb.wrap) activeDuty <= bufDuty;
    end

    assign chOut[c] = strb.run && (ctlReg[3:0] == MODE_PWM) && (extCount < activeDuty);
  end
endmodule

// File: rtl/pwm_shared_timebase.sv
module pwm_shared_timebase
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ALT_CH = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic              altSel,
  output logic [NUM_CH-1:0] pwmPin,
  output logic              altPin
);
  strobe_t           strb;
  logic [DUTY_W-1:0] extCount;
  logic [NUM_CH-1:0] chOut;

  pwm_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strb     (strb),
    .extCount (extCount)
  );

  pwm_datapath #(.NUM_CH(NUM_CH)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strb     (strb),
    .extCount (extCount),
    .chOut    (chOut)
  );

  always_comb begin
    pwmPin = chOut;
    altPin = 1'b0;
    if (altSel) begin
      pwmPin[ALT_CH] = 1'b0;
      altPin         = chOut[ALT_CH];
    end
  end
endmodule

// File: rtl/pwm_shared_timebase_chk.sv
module pwm_shared_timebase_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ALT_CH = 1
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           strb,
  input logic [DUTY_W-1:0] extCount,
  input logic              altSel,
  input logic [NUM_CH-1:0] pwmPin,
  input logic              altPin
);
  always_comb begin
    if (!rstN) begin
      p_reset_low_r1: assert (pwmPin == '0 && !altPin)
        else $error("outputs not low in reset");
    end
  end

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrap && !strb.clear) |=> (extCount == '0));

  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.wrap && !strb.clear) |=> (extCount == DUTY_W'($past(extCount) + 1'b1)));

  p_off_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> (pwmPin == '0 && !altPin));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clear) |=> $stable(extCount));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (extCount == '0));

  p_alt_own_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    altSel |-> !pwmPin[ALT_CH]);

  p_alt_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !altSel |-> !altPin);
endmodule

bind pwm_shared_timebase pwm_shared_timebase_chk #(.NUM_CH(NUM_CH), .ALT_CH(ALT_CH)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .extCount (extCount),
  .altSel   (altSel),
  .pwmPin   (pwmPin),
  .altPin   (altPin)
);

// File: tb/test_pwm_shared_timebase.sv
`timescale 1ns/1ps
module test_pwm_shared_timebase;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       altSel = 1'b0;
  logic [2:0] pwmPin;
  logic       altPin;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  pwm_shared_timebase i_pwm_shared_timebase (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .altSel(altSel), .pwmPin(pwmPin), .altPin(altPin)
  );

  typedef struct packed {
    logic [7:0]  per;
    logic [1:0]  ps;
    logic [9:0]  d0, d1, d2;
    logic [15:0] win;
    logic [15:0] e0, e1, e2;
  } vec_t;

  // period, prescale, duties, window cycles, expected high cycles per channel
  localparam vec_t VECS [5] = '{
    '{8'd3,   2'd0, 10'd5,   10'd0,    10'd16, 16'd16,   16'd5,   16'd0,    16'd16},
    '{8'd7,   2'd1, 10'd1,   10'd31,   10'd40, 16'd128,  16'd4,   16'd124,  16'd128},
    '{8'd1,   2'd2, 10'd3,   10'd8,    10'd7,  16'd128,  16'd48,  16'd128,  16'd112},
    '{8'd255, 2'd0, 10'd512, 10'd1023, 10'd1,  16'd1024, 16'd512, 16'd1023, 16'd1},
    '{8'd0,   2'd3, 10'd2,   10'd4,    10'd0,  16'd64,   16'd32,  16'd64,   16'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setup(input logic [7:0] per, input logic [1:0] ps,
                       input logic [9:0] d0, input logic [9:0] d1, input logic [9:0] d2);
    logic [9:0] dd [3];
    dd = '{d0, d1, d2};
    wr(4'd1, 8'h00);
    wr(4'd2, 8'h00);
    wr(4'd0, per);
    for (int c = 0; c < 3; c++) begin
      wr(4'(4 + 2*c), dd[c][9:2]);
      wr(4'(5 + 2*c), {2'b00, dd[c][1:0], 4'hC});
    end
    wr(4'd1, {5'b00000, 1'b1, ps});
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int cnt [3];
    int seg [2];
    int h;

    repeat (3) @(negedge clk);
    chk(pwmPin == 3'b000 && !altPin, "R1 outputs low in reset", int'(pwmPin), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pwmPin == 3'b000 && !altPin, "R1 outputs low after reset", int'(pwmPin), 0);

    // table-driven: duty, period and prescale combinations (R2 R3 R5 R8)
    for (int v = 0; v < 5; v++) begin
      setup(VECS[v].per, VECS[v].ps, VECS[v].d0, VECS[v].d1, VECS[v].d2);
      cnt = '{0, 0, 0};
      for (int i = 0; i < int'(VECS[v].win); i++) begin
        for (int c = 0; c < 3; c++) cnt[c] += int'(pwmPin[c]);
        @(negedge clk);
      end
      chk(cnt[0] == int'(VECS[v].e0), $sformatf("R3 R5 vec%0d ch0 high time", v), cnt[0], int'(VECS[v].e0));
      chk(cnt[1] == int'(VECS[v].e1), $sformatf("R3 R8 vec%0d ch1 high time", v), cnt[1], int'(VECS[v].e1));
      chk(cnt[2] == int'(VECS[v].e2), $sformatf("R3 R8 vec%0d ch2 high time", v), cnt[2], int'(VECS[v].e2));
      // new period starts right after the window on every channel
      chk(pwmPin == {VECS[v].d2 != 0, VECS[v].d1 != 0, VECS[v].d0 != 0},
          $sformatf("R2 vec%0d shared period restart", v), int'(pwmPin),
          int'({VECS[v].d2 != 0, VECS[v].d1 != 0, VECS[v].d0 != 0}));
    end

    // R9: duty write mid-period waits for the next period
    setup(8'd3, 2'd0, 10'd12, 10'd0, 10'd0);
    seg = '{0, 0};
    for (int i = 0; i < 32; i++) begin
      seg[i / 16] += int'(pwmPin[0]);
      if (i == 4)      wr(4'd4, 8'h00);
      else if (i == 5) wr(4'd5, 8'h2C);
      else             @(negedge clk);
    end
    chk(seg[0] == 12, "R9 current period keeps old duty", seg[0], 12);
    chk(seg[1] == 2,  "R9 next period uses new duty", seg[1], 2);

    // R6: stopping holds the count and forces outputs low
    setup(8'd3, 2'd0, 10'd8, 10'd0, 10'd0);
    h = 0;
    for (int i = 0; i < 4; i++) begin
      h += int'(pwmPin[0]);
      @(negedge clk);
    end
    chk(h == 4, "R6 high before stop", h, 4);
    wr(4'd1, 8'h00);
    h = 0;
    for (int i = 0; i < 6; i++) begin
      h += int'(pwmPin != 3'b000);
      @(negedge clk);
    end
    chk(h == 0, "R6 outputs low while stopped", h, 0);
    wr(4'd1, 8'h04);
    h = 0;
    for (int i = 0; i < 11; i++) begin
      h += int'(pwmPin[0]);
      @(negedge clk);
    end
    chk(h == 3, "R6 count resumes from held value", h, 3);
    chk(pwmPin[0] == 1'b1, "R6 period restarts after resume", int'(pwmPin[0]), 1);

    // R7: clear restarts the period
    setup(8'd3, 2'd0, 10'd8, 10'd0, 10'd0);
    repeat (10) @(negedge clk);
    chk(pwmPin[0] == 1'b0, "R7 low late in period", int'(pwmPin[0]), 0);
    wr(4'd2, 8'h00);
    h = 0;
    chk(pwmPin[0] == 1'b1, "R7 high right after clear", int'(pwmPin[0]), 1);
    for (int i = 0; i < 16; i++) begin
      h += int'(pwmPin[0]);
      @(negedge clk);
    end
    chk(h == 8, "R7 full period after clear", h, 8);

    // R4: only mode 1100 drives the pin; mode writes act at once
    setup(8'd3, 2'd0, 10'd16, 10'd16, 10'd16);
    wr(4'd5, 8'h08);
    wr(4'd9, 8'h00);
    chk(pwmPin == 3'b010, "R4 other modes held low", int'(pwmPin), 2);
    wr(4'd5, 8'h0C);
    chk(pwmPin[0] == 1'b1, "R4 enabling mode drives pin", int'(pwmPin[0]), 1);
    wr(4'd7, 8'h00);
    chk(pwmPin[1] == 1'b0, "R4 zero control turns channel off", int'(pwmPin[1]), 0);

    // R10: steering of channel 1
    wr(4'd7, 8'h0C);
    altSel = 1'b1;
    #1;
    chk(altPin == 1'b1 && pwmPin[1] == 1'b0, "R10 alt pin carries channel",
        int'({altPin, pwmPin[1]}), 2);
    @(negedge clk);
    altSel = 1'b0;
    #1;
    chk(altPin == 1'b0 && pwmPin[1] == 1'b1, "R10 primary pin carries channel",
        int'({altPin, pwmPin[1]}), 1);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule